// File: doc/BRIEF.md
# Link Control and Status Register File

This block holds the software-visible control and status words of a chip-to-chip data link. A small word-addressed bus (address, write enable, write data, registered read data) reaches eight 32-bit registers. They hold the link configuration, the transmit clock divider and phase settings, the input and output delay settings, and a 64-bit auto-address split across two words. Each configuration field leaves the block on its own output pin and feeds the datapath directly.

A status word reports six live FIFO conditions on the receive and transmit sides. Next to them sits a sticky mirror. A sticky bit latches whenever its live flag is seen high and stays set until software writes a one to it. Software can therefore catch brief full or empty events that it would miss by polling the live bits. The FIFOs and the framing datapath are outside this block.

Top module: `lcsr_top`

## Requirements
- R1: Register selection uses address bits [5:2] only: 0 config, 1 status, 2 clock divide, 3 clock phase, 4 input delay, 5 output delay, 6 auto-address low word, 7 auto-address high word. Address bits [1:0] are ignored.
- R2: After a synchronous reset every register reads zero, except the clock divide register, which reads all ones (0xFF). All sticky bits are clear.
- R3: Config bits drive the outputs as follows: bit 0 tx_off, bit 1 rx_off, [3:2] xfer_mode (00 packet, 01 streaming, 10 auto-address), [11:4] flits, bit 12 ddr_en, bit 13 msb_first, [18:14] pkt_ctrl.
- R4: Config bits [31:19] read as zero and ignore writes.
- R5: Clock divide holds 8 bits in [7:0], and the delay registers hold 8 bits in [7:0]. Their upper bits read zero.
- R6: Status bits [5:0] read the live fifo_flags inputs in this order: rx empty, rx programmable full, rx full, tx empty, tx programmable full, tx full. Bits [7:6] and [31:16] read zero.
- R7: Status bits [13:8] are sticky. A bit is set at any clock edge where its live flag is high, and it holds after the flag falls.
- R8: Writing 1 to a sticky bit clears it, and writing 0 leaves it alone. If the live flag is high in the same cycle as the clear, the bit stays set.
- R9: Writes to status bits [7:0] have no effect.
- R10: auto_addr equals {high word, low word}. clk_phase is the full 32-bit phase register.
- R11: rd_data is registered. It shows the register selected by the address on the previous clock edge, as that register stood before that edge.
- R12: A write updates the register and its field outputs at the clock edge where wr_en is high. Without wr_en the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address; bits [5:2] pick the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| fifo_flags | input | 6 | Live FIFO conditions, bit 0 rx empty to bit 5 tx full |
| tx_off | output | 1 | Transmit disable |
| rx_off | output | 1 | Receive disable |
| xfer_mode | output | 2 | Framing mode |
| flits | output | 8 | Flits per packet |
| ddr_en | output | 1 | Double data rate enable |
| msb_first | output | 1 | Most significant bit sent first |
| pkt_ctrl | output | 5 | Packet control mode |
| clk_div | output | 8 | Transmit clock period setting |
| clk_phase | output | 32 | Transmit clock edge placement |
| in_delay | output | 8 | Receive data delay |
| out_delay | output | 8 | Transmit data delay |
| auto_addr | output | 64 | Auto-address for auto-address mode |

## Verification
The bench goes after the sticky corner cases, where a mistake is easy to miss:
- A flag that pulses for one cycle must still be visible later. A design that merely mirrors the live flag would read zero there.
- A clear that lands in the same cycle as a new event must leave the bit set. A design that lets the clear win would lose that event.
- A zero written to the sticky field must change nothing, and a write to the live field must be ignored. A design that loads the status word plainly would do neither.

The bench also checks the other corner cases:
- Addresses with nonzero low bits must reach the same register.
- Writes of all ones must leave the reserved and upper bits reading zero.
- The read latency is tested by sampling rd_data before and after the edge. A combinational read path would change too early.

// File: rtl/lcsr_pkg.sv
package lcsr_pkg;
  localparam int BUS_W  = 32;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int IDX_LSB = 2;
  localparam int STAT_HALF = 8;

  typedef enum logic [IDX_W-1:0] {
    R_CFG   = 3'd0,
    R_STAT  = 3'd1,
    R_DIV   = 3'd2,
    R_PHASE = 3'd3,
    R_IDLY  = 3'd4,
    R_ODLY  = 3'd5,
    R_ALO   = 3'd6,
    R_AHI   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    XM_PACKET = 2'b00,
    XM_STREAM = 2'b01,
    XM_AUTO   = 2'b10
  } xfer_mode_e;

  typedef struct packed {
    logic [4:0] pkt_ctrl;
    logic       msb_first;
    logic       ddr_en;
    logic [7:0] flits;
    logic [1:0] mode;
    logic       rx_off;
    logic       tx_off;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lcsr_field.sv
module lcsr_field #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= d;
  end

  // R2
  rst_val_chk: assert property (@(posedge clk) rst |=> q == RST);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q));
endmodule

// File: rtl/lcsr_status.sv
module lcsr_status #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags_in,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] sticky_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              sticky_q[i] <= 1'b0;
      else if (flags_in[i]) sticky_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) sticky_q[i] <= 1'b0;
    end
  end

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|flags_in) |=> ((sticky_q & $past(flags_in)) == $past(flags_in)));

  // R8
  sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && |(clr_mask & ~flags_in)) |=> ((sticky_q & $past(clr_mask & ~flags_in)) == '0));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

// File: rtl/lcsr_rdmux.sv
module lcsr_rdmux
  import lcsr_pkg::*;
#(
  parameter int NFLAG   = 6,
  parameter int DIV_W   = 8,
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   idx,
  input  cfg_t               cfg,
  input  logic [NFLAG-1:0]   live,
  input  logic [NFLAG-1:0]   sticky,
  input  logic [DIV_W-1:0]   div,
  input  logic [BUS_W-1:0]   phase,
  input  logic [DELAY_W-1:0] idly,
  input  logic [DELAY_W-1:0] odly,
  input  logic [BUS_W-1:0]   alo,
  input  logic [BUS_W-1:0]   ahi,
  output logic [BUS_W-1:0]   rd_data
);
  logic [STAT_HALF-1:0] live8, sticky8;
  logic [BUS_W-1:0]     rd_n;

  assign live8   = STAT_HALF'(live);
  assign sticky8 = STAT_HALF'(sticky);

  always_comb begin
    case (reg_idx_e'(idx))
      R_CFG:   rd_n = BUS_W'(cfg);
      R_STAT:  rd_n = BUS_W'({sticky8, live8});
      R_DIV:   rd_n = BUS_W'(div);
      R_PHASE: rd_n = phase;
      R_IDLY:  rd_n = BUS_W'(idly);
      R_ODLY:  rd_n = BUS_W'(odly);
      R_ALO:   rd_n = alo;
      default: rd_n = ahi;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end
endmodule

// File: rtl/lcsr_top.sv
module lcsr_top
  import lcsr_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NFLAG   = 6,
  parameter int DIV_W   = 8,
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NFLAG-1:0]   fifo_flags,
  output logic               tx_off,
  output logic               rx_off,
  output logic [1:0]         xfer_mode,
  output logic [7:0]         flits,
  output logic               ddr_en,
  output logic               msb_first,
  output logic [4:0]         pkt_ctrl,
  output logic [DIV_W-1:0]   clk_div,
  output logic [31:0]        clk_phase,
  output logic [DELAY_W-1:0] in_delay,
  output logic [DELAY_W-1:0] out_delay,
  output logic [63:0]        auto_addr
);
  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  wsel;
  cfg_t             cfg_q;
  logic [NFLAG-1:0] sticky_q;
  logic [BUS_W-1:0] alo_q, ahi_q;

  assign idx = addr[IDX_LSB +: IDX_W];

  for (genvar i = 0; i < NREG; i++) begin : g_wsel
    assign wsel[i] = wr_en && (idx == IDX_W'(i));
  end

  lcsr_field #(.W(CFG_W), .RST('0)) u_cfg (
    .clk(clk), .rst(rst), .we(wsel[R_CFG]), .d(wr_data[CFG_W-1:0]), .q(cfg_q));

  lcsr_field #(.W(DIV_W), .RST({DIV_W{1'b1}})) u_div (
    .clk(clk), .rst(rst), .we(wsel[R_DIV]), .d(wr_data[DIV_W-1:0]), .q(clk_div));

  lcsr_field #(.W(BUS_W), .RST('0)) u_phase (
    .clk(clk), .rst(rst), .we(wsel[R_PHASE]), .d(wr_data), .q(clk_phase));

  lcsr_field #(.W(DELAY_W), .RST('0)) u_idly (
    .clk(clk), .rst(rst), .we(wsel[R_IDLY]), .d(wr_data[DELAY_W-1:0]), .q(in_delay));

  lcsr_field #(.W(DELAY_W), .RST('0)) u_odly (
    .clk(clk), .rst(rst), .we(wsel[R_ODLY]), .d(wr_data[DELAY_W-1:0]), .q(out_delay));

  lcsr_field #(.W(BUS_W), .RST('0)) u_alo (
    .clk(clk), .rst(rst), .we(wsel[R_ALO]), .d(wr_data), .q(alo_q));

  lcsr_field #(.W(BUS_W), .RST('0)) u_ahi (
    .clk(clk), .rst(rst), .we(wsel[R_AHI]), .d(wr_data), .q(ahi_q));

  lcsr_status #(.NFLAG(NFLAG)) u_stat (
    .clk(clk), .rst(rst), .flags_in(fifo_flags),
    .clr_we(wsel[R_STAT]), .clr_mask(wr_data[STAT_HALF +: NFLAG]),
    .sticky_q(sticky_q));

  lcsr_rdmux #(.NFLAG(NFLAG), .DIV_W(DIV_W), .DELAY_W(DELAY_W)) u_rd (
    .clk(clk), .rst(rst), .idx(idx), .cfg(cfg_q), .live(fifo_flags),
    .sticky(sticky_q), .div(clk_div), .phase(clk_phase), .idly(in_delay),
    .odly(out_delay), .alo(alo_q), .ahi(ahi_q), .rd_data(rd_data));

  assign tx_off    = cfg_q.tx_off;
  assign rx_off    = cfg_q.rx_off;
  assign xfer_mode = cfg_q.mode;
  assign flits     = cfg_q.flits;
  assign ddr_en    = cfg_q.ddr_en;
  assign msb_first = cfg_q.msb_first;
  assign pkt_ctrl  = cfg_q.pkt_ctrl;
  assign auto_addr = {ahi_q, alo_q};

  // R1
  one_write_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wsel));

  // R11
  rd_rst_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
endmodule

// File: tb/sim_lcsr_top.sv
`timescale 1ns/1ps
module sim_lcsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  fifo_flags = '0;
  logic        tx_off, rx_off, ddr_en, msb_first;
  logic [1:0]  xfer_mode;
  logic [7:0]  flits, clk_div, in_delay, out_delay;
  logic [4:0]  pkt_ctrl;
  logic [31:0] clk_phase;
  logic [63:0] auto_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  lcsr_top u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fifo_flags(fifo_flags), .tx_off(tx_off), .rx_off(rx_off),
    .xfer_mode(xfer_mode), .flits(flits), .ddr_en(ddr_en), .msb_first(msb_first),
    .pkt_ctrl(pkt_ctrl), .clk_div(clk_div), .clk_phase(clk_phase),
    .in_delay(in_delay), .out_delay(out_delay), .auto_addr(auto_addr));

  // {addr[5:0], write data, expected read-back}
  localparam logic [69:0] VEC [9] = '{
    {6'h00, 32'hFFFF_FFFF, 32'h0007_FFFF},   // R4
    {6'h08, 32'h1234_5678, 32'h0000_0078},   // R5
    {6'h0C, 32'hA5C3_0F1E, 32'hA5C3_0F1E},   // R10
    {6'h10, 32'hFFFF_FF3C, 32'h0000_003C},   // R5
    {6'h14, 32'h0000_1281, 32'h0000_0081},   // R5
    {6'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R10
    {6'h1C, 32'h0123_4567, 32'h0123_4567},   // R10
    {6'h04, 32'hFFFF_FFFF, 32'h0000_0000},   // R9
    {6'h03, 32'h0000_2A5A, 32'h0000_2A5A}    // R1
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] q);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    #1 q = rd_data;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset values at the ports and through the bus
    #1;
    chk("R2 div", 64'(clk_div), 64'hFF);
    chk("R2 cfg", 64'({pkt_ctrl, msb_first, ddr_en, flits, xfer_mode, rx_off, tx_off}), 64'h0);
    chk("R2 addr", auto_addr, 64'h0);
    for (int i = 0; i < 8; i++) begin
      rd(6'(i * 4), v);
      chk("R2 read", 64'(v), (i == 2) ? 64'hFF : 64'h0);
    end

    // table walk: write then read back
    for (int k = 0; k < 9; k++) begin
      wr(VEC[k][69:64], VEC[k][63:32]);
      rd(VEC[k][69:64], v);
      chk("R1/R4/R5/R9/R10 table", 64'(v), 64'(VEC[k][31:0]));
    end

    // R3 config fields from 0x2A5A
    chk("R3 fields a", 64'({pkt_ctrl, msb_first, ddr_en, flits, xfer_mode, rx_off, tx_off}),
        64'({5'd0, 1'b1, 1'b0, 8'hA5, 2'b10, 1'b1, 1'b0}));
    // R10 assembled address and phase
    chk("R10 auto_addr", auto_addr, 64'h0123_4567_DEAD_BEEF);
    chk("R10 phase", 64'(clk_phase), 64'hA5C3_0F1E);
    chk("R5 delays", 64'({in_delay, out_delay}), 64'h3C81);

    // R3 and R12 second config pattern, visible right after the write edge
    @(negedge clk);
    addr = 6'h00; wr_data = 32'h0005_5005; wr_en = 1'b1;
    @(posedge clk);
    #1 chk("R12 write edge", 64'({pkt_ctrl, msb_first, ddr_en, flits, xfer_mode, rx_off, tx_off}),
           64'({5'h15, 1'b0, 1'b1, 8'h00, 2'b01, 1'b0, 1'b1}));
    @(negedge clk);
    wr_en = 1'b0;

    // R11 read latency
    rd(6'h08, v);
    chk("R11 div", 64'(v), 64'h78);
    @(negedge clk);
    addr = 6'h00;
    #0.5 chk("R11 before edge", 64'(rd_data), 64'h78);
    @(posedge clk);
    #1 chk("R11 after edge", 64'(rd_data), 64'h0005_5005);

    // R7 one-cycle pulse is held
    @(negedge clk); fifo_flags = 6'b000101;
    @(negedge clk); fifo_flags = 6'b000000;
    rd(6'h04, v);
    chk("R7 held", 64'(v), 64'h0500);

    // R8 clear bit 8 only
    wr(6'h04, 32'h0000_0100);
    rd(6'h04, v);
    chk("R8 clear one", 64'(v), 64'h0400);

    // R8 zero in sticky field, R9 ones in live field
    wr(6'h04, 32'h0000_00FF);
    rd(6'h04, v);
    chk("R8/R9 no effect", 64'(v), 64'h0400);

    // R8 set wins over simultaneous clear
    @(negedge clk);
    fifo_flags = 6'b000100; addr = 6'h04; wr_data = 32'h0000_0400; wr_en = 1'b1;
    @(negedge clk);
    fifo_flags = 6'b000000; wr_en = 1'b0;
    rd(6'h04, v);
    chk("R8 set wins", 64'(v), 64'h0400);
    wr(6'h04, 32'h0000_0400);
    rd(6'h04, v);
    chk("R8 cleared", 64'(v), 64'h0000);

    // R6 live order and R7 capture timing
    @(negedge clk);
    fifo_flags = 6'b101010; addr = 6'h04;
    @(posedge clk);
    #1 chk("R6 live", 64'(rd_data), 64'h002A);
    @(posedge clk);
    #1 chk("R7 captured", 64'(rd_data), 64'h2A2A);
    @(negedge clk);
    fifo_flags = 6'b000000;
    @(posedge clk);
    #1 chk("R7 after fall", 64'(rd_data), 64'h2A00);
    wr(6'h04, 32'h0000_3F00);
    rd(6'h04, v);
    chk("R8 clear all", 64'(v), 64'h0000);

    // R12 registers hold without writes
    chk("R12 hold", auto_addr, 64'h0123_4567_DEAD_BEEF);

    // R2 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk("R2 re-reset div", 64'(clk_div), 64'hFF);
    chk("R2 re-reset addr", auto_addr, 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule